// File: doc/BRIEF.md
# Power-Up Strap Latch and Frequency Selector

This block manages six dual-purpose pads on a clock generator. Five pads carry the frequency-select code and one carries the divide choice for the super I/O clock. While reset is high, and for a fixed interval after it, the block keeps all six pad drivers turned off. During that interval the pads act as inputs, and external resistors pull them to the configured levels.

A counter runs on the free-running reference clock. When it reaches its terminal count, the block captures the six pad levels once. From then on it holds those levels until the next reset. One cycle after the capture it turns the pad drivers on, so the pads can carry clocks.

The block then produces three results:
- the active 5-bit select code, taken either from the captured straps or from register bits when an override bit is set;
- the spread-spectrum mode that belongs to that code;
- the divide choice for the super I/O clock.

A test bit in the same configuration register forces every pad driver off. Clock synthesis is done elsewhere.

Top module: `strap_select_top`

## Requirements
- R1: While `rst` is high, and after reset until the capture, `pad_oe` is 0, `straps_valid` is 0, `sel_code` is 0, `spread_mode` is 0 (off) and `sio_half` is 0.
- R2: The pad levels are captured exactly once, at the DELAY_CYCLES-th rising edge after `rst` falls. `straps_valid` is 1 after that edge. Later changes on `strap_in` have no effect on `sel_code` or `sio_half` until the next reset.
- R3: `pad_oe` stays 0 through the capture edge. It becomes 6'h3F at the next edge, provided test mode is off.
- R4: When `cfg_byte[3]` is 0, `sel_code` is the captured `strap_in[4:0]`, with bit 4 as the most significant bit. When `cfg_byte[3]` is 1, `sel_code` is {`cfg_byte[2]`, `cfg_byte[7:4]`}. Once the straps are captured, a change in `cfg_byte` shows on `sel_code` one clock later.
- R5: `spread_mode` is 1 (center 0.45%) for codes 01100 to 01111. It is 2 (down 0.6%) for codes 00001, 10011, 10101 and 11100 to 11111. It is 0 (off) for every other code. It changes in the same cycle as `sel_code`.
- R6: `sio_half` holds the captured `strap_in[5]`. A value of 1 means the super I/O clock is divided to 24 MHz; 0 means 48 MHz.
- R7: When `cfg_byte[0]` is 1, `pad_oe` is 0 one clock later. When the bit returns to 0, the drivers are enabled again one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_in | input | 6 | Pad input levels: [4:0] frequency strap, [5] super I/O divide strap |
| cfg_byte | input | 8 | Configuration byte: [7:4] and [2] override code, [3] override enable, [0] pad test disable |
| sel_code | output | 5 | Active frequency select code |
| spread_mode | output | 2 | 0 off, 1 center 0.45%, 2 down 0.6% |
| sio_half | output | 1 | 1 selects the 24 MHz super I/O clock |
| pad_oe | output | 6 | Output enables for the six dual-purpose pads |
| straps_valid | output | 1 | Pad levels have been captured |

## Verification
The select path is driven through the override with all 32 codes in turn. This separates each of the three spread classes at every class boundary, for example 01011 against 01100 and 11011 against 11100.

Two reset cycles use different strap patterns. One has the super I/O strap high and a center-spread code; the other has the strap low and a down-spread code. This separates the captured path from the override path and tells the two divide choices apart.

Toggling the pads after the capture, and setting the test bit, shows whether a late pin change or the test bit disturbs the held code or the driver enables.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int SEL_W = 5;
  localparam int CFG_W = 8;
  localparam int PAD_N = SEL_W + 1;

  // register byte bit positions (decoded by the serial register neighbour)
  localparam int CFG_TEST_BIT = 0;
  localparam int CFG_SEL4_BIT = 2;
  localparam int CFG_OVR_BIT  = 3;
  localparam int CFG_SELLO_LSB = 4;

  typedef enum logic [1:0] {
    SPR_OFF    = 2'd0,
    SPR_CENTER = 2'd1,
    SPR_DOWN   = 2'd2
  } spread_t;

  function automatic spread_t spread_of(input logic [SEL_W-1:0] code);
    spread_t m;
    m = SPR_OFF;
    if (code[4:2] == 3'b011) m = SPR_CENTER;
    else if (code[4:2] == 3'b111) m = SPR_DOWN;
    else if (code == 5'b00001 || code == 5'b10011 || code == 5'b10101) m = SPR_DOWN;
    return m;
  endfunction
endpackage

// File: rtl/strap_powerup_timer.sv
module strap_powerup_timer #(
  parameter int DELAY_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst,
  output logic expire
);
  localparam int CW = $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);
  localparam logic [CW-1:0] TOP  = CW'(DELAY_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign expire = (cnt == LAST);

  // R2: the count saturates and never passes the terminal value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst) cnt <= TOP);
  // R2: the capture strobe is a single-cycle pulse
  p_expire_once_r2: assert property (@(posedge clk) disable iff (rst) expire |=> !expire);
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int PINS = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            expire,
  input  logic [PINS-1:0] pins,
  output logic [PINS-1:0] held,
  output logic            valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      valid <= 1'b0;
    end else if (expire && !valid) begin
      held  <= pins;
      valid <= 1'b1;
    end
  end

  // R2: once captured, the held levels and the valid flag never change
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst) valid |=> ($stable(held) && valid));
  // R1: nothing is captured before the strobe
  p_no_early_r1: assert property (@(posedge clk) disable iff (rst) (!valid && !expire) |=> !valid);
endmodule

// File: rtl/strap_select_decode.sv
module strap_select_decode
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PAD_N-1:0] held,
  input  logic [CFG_W-1:0] cfg,
  output logic [SEL_W-1:0] sel_q,
  output spread_t          spr_q,
  output logic             sio_q
);
  logic [SEL_W-1:0] reg_code;
  logic [SEL_W-1:0] sel_d;

  assign reg_code = {cfg[CFG_SEL4_BIT], cfg[CFG_SELLO_LSB +: SEL_W-1]};
  assign sel_d    = cfg[CFG_OVR_BIT] ? reg_code : held[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      spr_q <= SPR_OFF;
      sio_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      spr_q <= spread_of(sel_d);
      sio_q <= held[SEL_W];
    end
  end

  // R5: only the three defined spread encodings appear
  p_spread_legal_r5: assert property (@(posedge clk) disable iff (rst) spr_q != 2'b11);
  // R4: override bits reach the code one cycle later
  p_override_r4: assert property (@(posedge clk) disable iff (rst)
    cfg[CFG_OVR_BIT] |=> (sel_q == $past(reg_code)));
  // R5: spread is off for the plain base codes
  p_spread_off_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_q[4:2] == 3'b000 && sel_q[1:0] != 2'b01) |-> spr_q == SPR_OFF);
endmodule

// File: rtl/strap_pad_enable.sv
module strap_pad_enable #(
  parameter int PINS = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            test_off,
  output logic [PINS-1:0] oe
);
  always_ff @(posedge clk) begin
    if (rst) oe <= '0;
    else     oe <= (valid && !test_off) ? '1 : '0;
  end

  // R3: drivers are never on before the capture has completed
  p_oe_after_valid_r3: assert property (@(posedge clk) disable iff (rst) (|oe) |-> valid);
  // R7: test bit turns every driver off on the next cycle
  p_test_off_r7: assert property (@(posedge clk) disable iff (rst) test_off |=> (oe == '0));
endmodule

// File: rtl/strap_select_top.sv
module strap_select_top
  import strap_pkg::*;
#(
  parameter int DELAY_CYCLES = 28636
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       strap_in,
  input  logic [7:0]       cfg_byte,
  output logic [4:0]       sel_code,
  output logic [1:0]       spread_mode,
  output logic             sio_half,
  output logic [5:0]       pad_oe,
  output logic             straps_valid
);
  logic             expire;
  logic [PAD_N-1:0] held;
  spread_t          spr;

  strap_powerup_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .expire(expire)
  );

  strap_capture #(.PINS(PAD_N)) u_cap (
    .clk(clk), .rst(rst), .expire(expire), .pins(strap_in),
    .held(held), .valid(straps_valid)
  );

  strap_select_decode u_dec (
    .clk(clk), .rst(rst), .held(held), .cfg(cfg_byte),
    .sel_q(sel_code), .spr_q(spr), .sio_q(sio_half)
  );

  assign spread_mode = spr;

  strap_pad_enable #(.PINS(PAD_N)) u_pad (
    .clk(clk), .rst(rst), .valid(straps_valid),
    .test_off(cfg_byte[CFG_TEST_BIT]), .oe(pad_oe)
  );

  // R1: drivers off while the pads are still being read as inputs
  p_oe_off_unlatched_r1: assert property (@(posedge clk) disable iff (rst)
    !straps_valid |-> (pad_oe == '0));
  // R6: divide choice never changes once captured
  p_sio_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (straps_valid && $past(straps_valid)) |=> $stable(sio_half));
endmodule

// File: tb/sim_strap_select_top.sv
module sim_strap_select_top;
  localparam int DLY = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] strap_in = 6'b1_01101;
  logic [7:0] cfg_byte = 8'h00;
  logic [4:0] sel_code;
  logic [1:0] spread_mode;
  logic       sio_half;
  logic [5:0] pad_oe;
  logic       straps_valid;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [4:0] code;
    logic [1:0] spr;
    logic       sio;
    logic [5:0] oe;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strap_select_top #(.DELAY_CYCLES(DLY)) u0 (
    .clk(clk), .rst(rst), .strap_in(strap_in), .cfg_byte(cfg_byte),
    .sel_code(sel_code), .spread_mode(spread_mode), .sio_half(sio_half),
    .pad_oe(pad_oe), .straps_valid(straps_valid)
  );

  function automatic logic [1:0] exp_spread(input logic [4:0] c);
    if (c >= 5'd12 && c <= 5'd15) return 2'd1;
    if (c == 5'd1 || c == 5'd19 || c == 5'd21 || c >= 5'd28) return 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: set cfg at a falling edge and queue the expectation for the next one
  task automatic drive_cfg(input logic [7:0] v, input logic [4:0] code, input logic sio,
                           input logic [5:0] oe, input string req);
    exp_t e;
    @(negedge clk);
    cfg_byte = v;
    e.due = cyc + 1; e.code = code; e.spr = exp_spread(code);
    e.sio = sio; e.oe = oe; e.req = req;
    sb.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0 && cyc >= sb[0].due) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "sel_code", sel_code, e.code);
      chk("R5", "spread_mode", spread_mode, e.spr);
      chk("R6", "sio_half", sio_half, e.sio);
      chk(e.req, "pad_oe", pad_oe, e.oe);
    end
  end

  task automatic start_after_reset(input logic [5:0] straps);
    @(negedge clk);
    rst = 1'b1;
    strap_in = straps;
    repeat (3) @(negedge clk);
    chk("R1", "pad_oe in reset", pad_oe, 0);
    chk("R1", "valid in reset", straps_valid, 0);
    chk("R1", "sel_code in reset", sel_code, 0);
    rst = 1'b0;
    repeat (DLY - 1) @(negedge clk);
    chk("R1", "valid before capture", straps_valid, 0);
    chk("R1", "pad_oe before capture", pad_oe, 0);
    @(negedge clk);
    chk("R2", "valid at capture", straps_valid, 1);
    chk("R3", "pad_oe at capture edge", pad_oe, 0);
    @(negedge clk);
    chk("R3", "pad_oe after capture", pad_oe, 6'h3F);
  endtask

  initial begin
    start_after_reset(6'b1_01101);
    chk("R4", "strapped code", sel_code, 5'b01101);
    chk("R5", "strapped spread", spread_mode, 1);
    chk("R6", "sio strap high", sio_half, 1);

    // R2: later pin activity is ignored
    strap_in = 6'b0_10010;
    repeat (4) @(negedge clk);
    chk("R2", "code after pin change", sel_code, 5'b01101);
    chk("R2", "sio after pin change", sio_half, 1);

    // R4/R5: override sweep of every code
    for (int v = 0; v < 32; v++) begin
      logic [4:0] c;
      c = 5'(v);
      drive_cfg({c[3:0], 1'b1, c[4], 2'b00}, c, 1'b1, 6'h3F, "R4");
    end
    drive_cfg(8'h00, 5'b01101, 1'b1, 6'h3F, "R4");
    // R7: test bit disables drivers, clearing restores them
    drive_cfg(8'h01, 5'b01101, 1'b1, 6'h00, "R7");
    drive_cfg(8'h00, 5'b01101, 1'b1, 6'h3F, "R7");
    repeat (3) @(negedge clk);

    // second power-up with different straps
    start_after_reset(6'b0_00001);
    chk("R4", "strapped code 2", sel_code, 5'b00001);
    chk("R5", "down spread strap", spread_mode, 2);
    chk("R6", "sio strap low", sio_half, 0);
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule